// File: doc/BRIEF.md
# Card Presence Detect Unit

This block watches the raw card-detect contact of a removable memory card socket and turns it into a clean card-present status bit. The raw level first passes through a two-stage synchronizer. A counter then requires the new level to hold for a parameterised number of clock cycles before the status follows it, so contact bounce and short glitches never reach the status. Detection runs all the time, whatever the state of bus power.

Each edge of the debounced status sets a sticky interrupt flag: a rising edge sets the insertion flag and a falling edge sets the removal flag. Software clears a flag by pulsing its clear input. A flag reaches the shared interrupt line only when its enable is set.

On removal the block stops driving the bus pads at once. The command and data output enables are gated off starting in the same cycle the status falls. They stay off until software acknowledges the removal, even if a card is pushed back in first. If the card leaves while bus power and the bus clock are both enabled, the block sends one-cycle clear strobes to those two controls. A full software reset clears the interrupt flags but leaves the present bit and the debouncer untouched. The block has no data stream, so every pin is a plain level or strobe and there is no handshake.

Top module: `card_detect_unit`

## Requirements
- R1: While `rst_n` is low and right after it is released, `card_present`, `ins_pend`, `rem_pend`, `irq`, `pwr_clr` and `clk_clr` are 0.
- R2: `card_present` takes the synchronized level of `cd_raw` only after that level has differed from the status on DEBOUNCE_CYCLES consecutive clock edges. A level held for fewer edges has no effect. A clean step of `cd_raw` shows on `card_present` DEBOUNCE_CYCLES+2 edges after it is sampled.
- R3: A 0-to-1 change of `card_present` sets `ins_pend` at the same clock edge.
- R4: A 1-to-0 change of `card_present` sets `rem_pend` at the same clock edge.
- R5: Each flag is sticky until its clear input (`ins_clr` or `rem_clr`) is high at an edge. A setting event wins over a clear or a software reset in the same cycle.
- R6: `irq` = (`ins_pend` AND `ins_irq_en`) OR (`rem_pend` AND `rem_irq_en`).
- R7: `soft_rst` clears both flags, but it does not change `card_present` and does not interrupt a debounce already in progress.
- R8: `cmd_oe` follows `cmd_oe_req`, and bit i of `dat_oe` follows bit i of `dat_oe_req`, except while `rem_pend` is 1. Then all of them are 0, starting in the cycle `card_present` falls and including any time a card is reinserted before the flag is cleared.
- R9: `pwr_clr` and `clk_clr` pulse high for exactly the cycle in which `card_present` first reads 0 after a removal, and only when `pwr_en` and `clk_en` were both 1 at that edge. Otherwise they stay 0.
- R10: Insertion and removal are detected the same way whether `pwr_en` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous full software reset request |
| cd_raw | input | 1 | Raw socket detect level, 1 = card seen |
| pwr_en | input | 1 | Bus power control bit |
| clk_en | input | 1 | Bus clock enable control bit |
| ins_irq_en | input | 1 | Enable for the insertion flag onto `irq` |
| rem_irq_en | input | 1 | Enable for the removal flag onto `irq` |
| ins_clr | input | 1 | Write-one-to-clear pulse for the insertion flag |
| rem_clr | input | 1 | Write-one-to-clear pulse for the removal flag |
| cmd_oe_req | input | 1 | Command pad drive request from the bus engine |
| dat_oe_req | input | DAT_W | Data pad drive requests |
| card_present | output | 1 | Debounced card-present status |
| ins_pend | output | 1 | Sticky insertion flag |
| rem_pend | output | 1 | Sticky removal flag |
| irq | output | 1 | Masked interrupt request |
| cmd_oe | output | 1 | Gated command pad output enable |
| dat_oe | output | DAT_W | Gated data pad output enables |
| pwr_clr | output | 1 | One-cycle strobe that clears bus power |
| clk_clr | output | 1 | One-cycle strobe that clears the bus clock enable |

## Verification
The assertions check on every cycle that each status edge raises its flag at once, that the pads are off whenever removal is pending, that the clear strobes appear only with a freshly dropped status after power and clock were both on, and that the debounce counter stays in range. Only the bench scenarios can show the exact debounce latency, that glitches shorter than the window are rejected, that a software reset in the middle of a debounce lets the count finish, and that reinsertion before acknowledgement keeps the pads off. The bench shows these by comparing every output each cycle against a behavioural model.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [0:0] {
    EVT_INS = 1'b0,
    EVT_REM = 1'b1
  } cd_evt_e;

  localparam int unsigned NUM_EVT = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } cd_edge_t;
endpackage

// File: rtl/cd_debounce.sv
module cd_debounce #(
  parameter int unsigned DEBOUNCE_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_in,
  output logic            stable,
  output cd_pkg::cd_edge_t edge_o
);
  localparam int unsigned CNT_W = (DEBOUNCE_CYCLES < 2) ? 1 : $clog2(DEBOUNCE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [1:0]       sync_q;
  logic             synced;
  logic             stable_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             flip;

  assign synced  = sync_q[1];
  assign differs = synced ^ stable_q;
  assign flip    = differs && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], raw_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (flip) begin
      cnt_q    <= '0;
      stable_q <= synced;
    end else if (differs) begin
      cnt_q    <= cnt_q + 1'b1;
    end else begin
      cnt_q    <= '0;
    end
  end

  assign stable      = stable_q;
  assign edge_o.rise = flip & synced;
  assign edge_o.fall = flip & ~synced;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R2
  AST_FLIP_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_q != $past(stable_q)) |-> (stable_q == $past(synced))); // R2
endmodule

// File: rtl/cd_irq_status.sv
module cd_irq_status (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic [cd_pkg::NUM_EVT-1:0] set_i,
  input  logic [cd_pkg::NUM_EVT-1:0] clr_i,
  input  logic [cd_pkg::NUM_EVT-1:0] en_i,
  output logic [cd_pkg::NUM_EVT-1:0] pend_o,
  output logic                       irq_o
);
  logic [cd_pkg::NUM_EVT-1:0] pend_q;

  for (genvar g = 0; g < cd_pkg::NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (set_i[g]) begin
        pend_q[g] <= 1'b1;
      end else if (clr_i[g] || soft_rst) begin
        pend_q[g] <= 1'b0;
      end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]); // R5
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/cd_pad_guard.sv
module cd_pad_guard #(
  parameter int unsigned DAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             fall,
  input  logic             pwr_en,
  input  logic             clk_en,
  input  logic             cmd_req,
  input  logic [DAT_W-1:0] dat_req,
  output logic             cmd_oe,
  output logic [DAT_W-1:0] dat_oe,
  output logic             pwr_clr,
  output logic             clk_clr
);
  logic kill_q;

  assign cmd_oe = cmd_req & ~lock;

  for (genvar i = 0; i < DAT_W; i++) begin : g_dat
    assign dat_oe[i] = dat_req[i] & ~lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q <= 1'b0;
    end else begin
      kill_q <= fall & pwr_en & clk_en;
    end
  end

  assign pwr_clr = kill_q;
  assign clk_clr = kill_q;

  AST_KILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q |=> !kill_q); // R9
endmodule

// File: rtl/card_detect_unit.sv
module card_detect_unit #(
  parameter int unsigned DEBOUNCE_CYCLES = 1024,
  parameter int unsigned DAT_W           = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cd_raw,
  input  logic             pwr_en,
  input  logic             clk_en,
  input  logic             ins_irq_en,
  input  logic             rem_irq_en,
  input  logic             ins_clr,
  input  logic             rem_clr,
  input  logic             cmd_oe_req,
  input  logic [DAT_W-1:0] dat_oe_req,
  output logic             card_present,
  output logic             ins_pend,
  output logic             rem_pend,
  output logic             irq,
  output logic             cmd_oe,
  output logic [DAT_W-1:0] dat_oe,
  output logic             pwr_clr,
  output logic             clk_clr
);
  import cd_pkg::*;

  cd_edge_t             edg;
  logic [NUM_EVT-1:0]   set_v;
  logic [NUM_EVT-1:0]   clr_v;
  logic [NUM_EVT-1:0]   en_v;
  logic [NUM_EVT-1:0]   pend_v;

  cd_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (cd_raw),
    .stable (card_present),
    .edge_o (edg)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    en_v  = '0;
    set_v[EVT_INS] = edg.rise;
    set_v[EVT_REM] = edg.fall;
    clr_v[EVT_INS] = ins_clr;
    clr_v[EVT_REM] = rem_clr;
    en_v[EVT_INS]  = ins_irq_en;
    en_v[EVT_REM]  = rem_irq_en;
  end

  cd_irq_status u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .en_i     (en_v),
    .pend_o   (pend_v),
    .irq_o    (irq)
  );

  assign ins_pend = pend_v[EVT_INS];
  assign rem_pend = pend_v[EVT_REM];

  cd_pad_guard #(.DAT_W(DAT_W)) u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (rem_pend),
    .fall    (edg.fall),
    .pwr_en  (pwr_en),
    .clk_en  (clk_en),
    .cmd_req (cmd_oe_req),
    .dat_req (dat_oe_req),
    .cmd_oe  (cmd_oe),
    .dat_oe  (dat_oe),
    .pwr_clr (pwr_clr),
    .clk_clr (clk_clr)
  );

  AST_RISE_FLAGS_INS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_present) |-> ins_pend); // R3
  AST_FALL_FLAGS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_present) |-> rem_pend); // R4
  AST_PADS_OFF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_present) |-> (!cmd_oe && dat_oe == '0)); // R8
  AST_KILL_NEEDS_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_clr |-> ($fell(card_present) && $past(pwr_en && clk_en))); // R9
  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_clr == clk_clr); // R9
endmodule

// File: tb/card_detect_unit_test.sv
module card_detect_unit_test;
  localparam int unsigned N  = 20;
  localparam int unsigned DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, cd_raw = 1'b0, pwr_en = 1'b0, clk_en = 1'b0;
  logic ins_irq_en = 1'b0, rem_irq_en = 1'b0, ins_clr = 1'b0, rem_clr = 1'b0;
  logic cmd_oe_req = 1'b0;
  logic [DW-1:0] dat_oe_req = '0;
  logic card_present, ins_pend, rem_pend, irq, cmd_oe, pwr_clr, clk_clr;
  logic [DW-1:0] dat_oe;

  int vectors = 0;
  int miscompares = 0;

  card_detect_unit #(.DEBOUNCE_CYCLES(N), .DAT_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cd_raw(cd_raw),
    .pwr_en(pwr_en), .clk_en(clk_en), .ins_irq_en(ins_irq_en),
    .rem_irq_en(rem_irq_en), .ins_clr(ins_clr), .rem_clr(rem_clr),
    .cmd_oe_req(cmd_oe_req), .dat_oe_req(dat_oe_req),
    .card_present(card_present), .ins_pend(ins_pend), .rem_pend(rem_pend),
    .irq(irq), .cmd_oe(cmd_oe), .dat_oe(dat_oe), .pwr_clr(pwr_clr), .clk_clr(clk_clr)
  );

  always #5 clk = ~clk;

  // Behavioural reference: a delay queue for the synchronizer and a run-length count.
  bit q_sync[$];
  bit m_pres = 0, m_ins = 0, m_rem = 0, m_kill = 0;
  int m_run = 0;

  initial begin
    q_sync.push_back(0);
    q_sync.push_back(0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sync = {};
      q_sync.push_back(0);
      q_sync.push_back(0);
      m_pres = 0; m_ins = 0; m_rem = 0; m_kill = 0; m_run = 0;
    end else begin
      bit seen, rise, fall;
      seen = q_sync[0];
      rise = 0; fall = 0;
      if (seen != m_pres) begin
        m_run++;
        if (m_run == N) begin
          rise = seen; fall = !seen; m_pres = seen; m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      if (rise) m_ins = 1; else if (ins_clr || soft_rst) m_ins = 0;
      if (fall) m_rem = 1; else if (rem_clr || soft_rst) m_rem = 0;
      m_kill = fall && pwr_en && clk_en;
      void'(q_sync.pop_front());
      q_sync.push_back(cd_raw);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2", "card_present", card_present, m_pres);
    chk("R3", "ins_pend", ins_pend, m_ins);
    chk("R4", "rem_pend", rem_pend, m_rem);
    chk("R6", "irq", irq, (m_ins && ins_irq_en) || (m_rem && rem_irq_en));
    chk("R8", "cmd_oe", cmd_oe, cmd_oe_req && !m_rem);
    chk("R8", "dat_oe", dat_oe, m_rem ? 0 : dat_oe_req);
    chk("R9", "pwr_clr", pwr_clr, m_kill);
    chk("R9", "clk_clr", clk_clr, m_kill);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse_clr(input bit ins, input bit rem);
    ins_clr = ins; rem_clr = rem;
    step(1);
    ins_clr = 0; rem_clr = 0;
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(3);
    chk("R1", "present in reset", card_present, 0);
    chk("R1", "strobe in reset", pwr_clr, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "flags after reset", {ins_pend, rem_pend, irq}, 0);

    cmd_oe_req = 1; dat_oe_req = 4'b1011; ins_irq_en = 1; rem_irq_en = 1;
    // R2: glitch shorter than the window is ignored
    cd_raw = 1; step(N - 3); cd_raw = 0; step(N + 6);
    chk("R2", "glitch rejected", card_present, 0);

    // R10: insertion with power off; R2 latency N+2 edges after sampling
    cd_raw = 1;
    step(N + 1);
    chk("R2", "not yet present", card_present, 0);
    step(1);
    chk("R10", "present with power off", card_present, 1);
    chk("R3", "ins flag", ins_pend, 1);
    chk("R6", "irq from ins", irq, 1);
    ins_irq_en = 0; step(1);
    chk("R6", "irq masked", irq, 0);
    pulse_clr(1, 0);
    chk("R5", "ins cleared", ins_pend, 0);

    // R9/R4/R8: removal while powered and clocked
    pwr_en = 1; clk_en = 1;
    cd_raw = 0; step(N + 2);
    chk("R4", "rem flag", rem_pend, 1);
    chk("R9", "pwr strobe", pwr_clr, 1);
    chk("R8", "pads off", {cmd_oe, dat_oe}, 0);
    step(1);
    chk("R9", "strobe single", pwr_clr, 0);

    // R8: reinsertion keeps pads off until removal acknowledged
    cd_raw = 1; step(N + 4);
    chk("R8", "reinsert locked", cmd_oe, 0);
    pulse_clr(0, 1);
    chk("R8", "pads back", {cmd_oe, dat_oe}, {1'b1, 4'b1011});

    // R7: soft reset mid-debounce; removal with clock off gives no strobe
    clk_en = 0;
    cd_raw = 0; step(6);
    soft_rst = 1; step(1); soft_rst = 0;
    chk("R7", "ins cleared by soft reset", ins_pend, 0);
    chk("R7", "present kept", card_present, 1);
    step(N - 5);
    chk("R7", "debounce completed", card_present, 0);
    chk("R9", "no strobe, clock off", pwr_clr, 0);

    // R5: clear and set in the same cycle; set wins
    pulse_clr(0, 1);
    cd_raw = 1; step(N + 1);
    ins_clr = 1; step(1); ins_clr = 0;
    chk("R5", "set beats clear", ins_pend, 1);

    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule